// File: doc/BRIEF.md
# Pointwise Multiply-Accumulate Channel Unit

This block produces one output channel of a 1×1 convolution. A stream of signed 8-bit input features is presented together with matching signed 8-bit filter weights, one input channel per valid cycle. A flag on the final input channel of each pixel closes the dot product. The running sum does not start from zero. It starts from the filter bias, aligned to the fixed-point format. When the pixel closes, the sum is shifted back to integer scale and saturated into the signed 8-bit range.

A build-time option adds a normalisation stage behind the first saturation. This stage multiplies the saturated value by a per-channel scale, adds an aligned offset, shifts, and saturates again. The scale/offset pair is captured together with the closing channel and is delayed so that it meets its own pixel's value. A second build-time option selects a rectified activation, which raises the lower bound of the final saturation to zero. Each finished pixel comes out as one result byte with a single-cycle valid strobe. The result stays on the output until the next strobe.

Top module: `pw_mac_unit`

## Requirements
- R1: While reset is low at a clock edge, out_valid and out_data are 0 after that edge. The first valid cycle after reset starts a new pixel.
- R2: The first valid cycle of a pixel is the first valid cycle after reset or after a valid cycle with in_last high. On that cycle the sum is in_bias·2^FRAC_BITS + in_data·in_weight. Each later valid cycle of the same pixel adds in_data·in_weight. All operands are signed two's complement.
- R3: A cycle with in_valid low changes nothing, whatever the other inputs carry. This holds for in_last too: a cycle with in_valid low and in_last high does not close the pixel.
- R4: Without activation, a closed pixel's value is floor(sum / 2^FRAC_BITS) saturated to [−128, 127].
- R5: With the rectified activation, the final saturation uses the range [0, 127].
- R6: Without normalisation, out_valid is high for exactly one cycle, right after the clock edge that takes the pixel's last valid channel. Back-to-back closing cycles give back-to-back strobes.
- R7: With normalisation, out_valid comes one pipeline register per stage later, three edges in all, counting the edge that takes the last channel.
- R8: With normalisation, the result is floor((scale·x + offset·2^FRAC_BITS) / 2^FRAC_BITS) saturated. Here x is the pixel value saturated to [−128, 127], and scale and offset are the values of nrm_scale and nrm_offset on the pixel's last valid cycle.
- R9: With normalisation and the rectified activation, the first saturation still uses [−128, 127]. Only the saturation after normalisation uses [0, 127].
- R10: out_data changes only in cycles where out_valid is high. Between strobes it holds the last result.
- R11: A pixel with one input channel, where in_last is high on its first valid cycle, yields bias plus one product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Channel operands present this cycle |
| in_last | input | 1 | Operands belong to the pixel's final input channel |
| in_data | input | 8 | Signed input feature |
| in_weight | input | 8 | Signed filter weight |
| in_bias | input | 8 | Signed bias, taken on the pixel's first valid cycle |
| nrm_scale | input | 8 | Signed normalisation scale, taken on the closing cycle |
| nrm_offset | input | 8 | Signed normalisation offset, taken on the closing cycle |
| out_valid | output | 1 | One-cycle strobe per finished pixel |
| out_data | output | 8 | Signed result byte |

## Verification
Three builds are fed the same stimulus: normalised with no activation, plain with the rectified activation, and normalised with the rectified activation. This lets the two saturation stages be told apart. A sweep of single-channel pixels crosses input values with extreme and ordinary weights and several biases. It drives both bounds and the floor behaviour of the shift on negative sums. A grid over scale and offset with fixed pixel values isolates the normalisation arithmetic and its second clamp. Random multi-channel pixels are then interleaved with idle cycles that carry garbage operands and stray last flags, together with back-to-back closes. These separate a correct bias restart from an accumulator that leaks between pixels or responds to invalid cycles.

// File: rtl/pw_mac_pkg.sv
// Shared types for the pointwise multiply-accumulate channel unit.
// Assumes operand bytes are signed two's complement.
package pw_mac_pkg;
    // Operand byte as carried on every data-like port.
    typedef logic signed [7:0] op_byte_t;

    // Pipeline depth of the result for a given normalisation choice.
    function automatic int result_latency(input int norm_en);
        return (norm_en != 0) ? 3 : 1;
    endfunction
endpackage

// File: rtl/pw_mac_accum.sv
// Bias-initialised multiply-accumulate with a new-point flag.
// Purpose: keeps the running dot product of one output channel.
// Assumes: the first valid cycle after reset or after a valid cycle with
// last_i high belongs to a new pixel (R2); invalid cycles are ignored (R3).
// sum_o is the value the accumulator takes at the coming edge, so the
// closing cycle's total can be saturated without an extra register.
module pw_mac_accum #(
    parameter int DATA_W    = 8,
    parameter int ACC_W     = 24,
    parameter int FRAC_BITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic                     last_i,
    input  logic signed [DATA_W-1:0] data_i,
    input  logic signed [DATA_W-1:0] wgt_i,
    input  logic signed [DATA_W-1:0] bias_i,
    output logic                     first_o,
    output logic signed [ACC_W-1:0]  sum_o
);
    localparam int PROD_W = 2 * DATA_W;

    logic                     first_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  bias_ext;
    logic signed [ACC_W-1:0]  bias_al;
    logic signed [ACC_W-1:0]  base;

    // Product, sign extension, bias alignment and operand selection.
    always_comb begin
        prod     = data_i * wgt_i;
        prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        bias_ext = {{(ACC_W-DATA_W){bias_i[DATA_W-1]}}, bias_i};
        bias_al  = bias_ext <<< FRAC_BITS;
        base     = first_q ? bias_al : acc_q;
        sum_o    = base + prod_ext;
    end

    // Accumulator and new-point flag, advanced only on valid cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            acc_q   <= '0;
        end else if (vld_i) begin
            acc_q   <= sum_o;
            first_q <= last_i;
        end
    end

    assign first_o = first_q;
endmodule

// File: rtl/pw_limit.sv
// Saturating limit: arithmetic right shift by SHIFT, then clamp to the
// signed OUT_W range, or to [0, max] when RELU is set (R4, R5).
// Purely combinational; assumes IN_W > OUT_W + SHIFT.
module pw_limit #(
    parameter int IN_W  = 24,
    parameter int OUT_W = 8,
    parameter int SHIFT = 4,
    parameter int RELU  = 0
) (
    input  logic signed [IN_W-1:0]  val_i,
    output logic signed [OUT_W-1:0] val_o
);
    localparam logic signed [IN_W-1:0] HI = IN_W'((2 ** (OUT_W-1)) - 1);
    localparam logic signed [IN_W-1:0] LO = (RELU != 0) ? '0 : ~HI;

    logic signed [IN_W-1:0] scaled;

    // Shift to integer scale and pick the bound or the value itself.
    always_comb begin
        scaled = val_i >>> SHIFT;
        if (scaled > HI) begin
            val_o = HI[OUT_W-1:0];
        end else if (scaled < LO) begin
            val_o = LO[OUT_W-1:0];
        end else begin
            val_o = scaled[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/pw_norm_stage.sv
// Affine normalisation stage: y = limit(scale * x + offset << FRAC_BITS).
// Purpose: two-register back end of the channel unit (R7, R8, R9).
// Assumes: cap_i is high on the edge where x_i's pixel is captured upstream,
// so the pair registered here lines up with x_i one edge later.
module pw_norm_stage #(
    parameter int DATA_W    = 8,
    parameter int ACC_W     = 24,
    parameter int FRAC_BITS = 4,
    parameter int RELU      = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_i,
    input  logic signed [DATA_W-1:0] scale_i,
    input  logic signed [DATA_W-1:0] offset_i,
    input  logic                     x_vld_i,
    input  logic signed [DATA_W-1:0] x_i,
    output logic                     y_vld_o,
    output logic signed [DATA_W-1:0] y_o
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [DATA_W-1:0] sc_q;
    logic signed [DATA_W-1:0] of_q;
    logic signed [PROD_W-1:0] mul;
    logic signed [ACC_W-1:0]  mul_ext;
    logic signed [ACC_W-1:0]  of_ext;
    logic signed [ACC_W-1:0]  aff;
    logic signed [ACC_W-1:0]  aff_q;
    logic                     aff_vld_q;
    logic signed [DATA_W-1:0] lim;
    logic signed [DATA_W-1:0] y_q;
    logic                     y_vld_q;

    // Delay the scale/offset pair by one edge to meet its pixel's value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= '0;
            of_q <= '0;
        end else if (cap_i) begin
            sc_q <= scale_i;
            of_q <= offset_i;
        end
    end

    // Affine product with the offset aligned to the fixed-point format.
    always_comb begin
        mul     = x_i * sc_q;
        mul_ext = {{(ACC_W-PROD_W){mul[PROD_W-1]}}, mul};
        of_ext  = {{(ACC_W-DATA_W){of_q[DATA_W-1]}}, of_q};
        aff     = mul_ext + (of_ext <<< FRAC_BITS);
    end

    // Register the affine result of each arriving pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aff_q     <= '0;
            aff_vld_q <= 1'b0;
        end else begin
            aff_vld_q <= x_vld_i;
            if (x_vld_i) begin
                aff_q <= aff;
            end
        end
    end

    pw_limit #(
        .IN_W (ACC_W),
        .OUT_W(DATA_W),
        .SHIFT(FRAC_BITS),
        .RELU (RELU)
    ) u_lim2 (
        .val_i(aff_q),
        .val_o(lim)
    );

    // Output register: take the saturated value, hold it between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q     <= '0;
            y_vld_q <= 1'b0;
        end else begin
            y_vld_q <= aff_vld_q;
            if (aff_vld_q) begin
                y_q <= lim;
            end
        end
    end

    assign y_o     = y_q;
    assign y_vld_o = y_vld_q;
endmodule

// File: rtl/pw_mac_unit.sv
// Pointwise multiply-accumulate channel unit (top).
// Purpose: one output channel of a 1x1 convolution, with bias start,
// saturation, optional affine normalisation and optional rectification.
// Assumes: operands are signed; ACC_W is wide enough for the longest pixel;
// with NORM_EN the activation applies only after normalisation (R9).
module pw_mac_unit #(
    parameter int DATA_W    = 8,
    parameter int ACC_W     = 24,
    parameter int FRAC_BITS = 4,
    parameter int NORM_EN   = 1,
    parameter int RELU_EN   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DATA_W-1:0] in_weight,
    input  logic [DATA_W-1:0] in_bias,
    input  logic [DATA_W-1:0] nrm_scale,
    input  logic [DATA_W-1:0] nrm_offset,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int FIRST_RELU = ((NORM_EN == 0) && (RELU_EN != 0)) ? 1 : 0;

    logic                     first_ch;
    logic                     close_px;
    logic signed [ACC_W-1:0]  sum;
    logic signed [DATA_W-1:0] lim1;
    logic signed [DATA_W-1:0] x1_q;
    logic                     x1_vld_q;

    assign close_px = in_valid & in_last;

    pw_mac_accum #(
        .DATA_W   (DATA_W),
        .ACC_W    (ACC_W),
        .FRAC_BITS(FRAC_BITS)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (in_valid),
        .last_i (in_last),
        .data_i ($signed(in_data)),
        .wgt_i  ($signed(in_weight)),
        .bias_i ($signed(in_bias)),
        .first_o(first_ch),
        .sum_o  (sum)
    );

    pw_limit #(
        .IN_W (ACC_W),
        .OUT_W(DATA_W),
        .SHIFT(FRAC_BITS),
        .RELU (FIRST_RELU)
    ) u_lim1 (
        .val_i(sum),
        .val_o(lim1)
    );

    // First result register: saturated pixel value and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x1_q     <= '0;
            x1_vld_q <= 1'b0;
        end else begin
            x1_vld_q <= close_px;
            if (close_px) begin
                x1_q <= lim1;
            end
        end
    end

    generate
        if (NORM_EN != 0) begin : g_norm
            logic signed [DATA_W-1:0] y;
            logic                     y_vld;

            pw_norm_stage #(
                .DATA_W   (DATA_W),
                .ACC_W    (ACC_W),
                .FRAC_BITS(FRAC_BITS),
                .RELU     (RELU_EN)
            ) u_norm (
                .clk     (clk),
                .rst_n   (rst_n),
                .cap_i   (close_px),
                .scale_i ($signed(nrm_scale)),
                .offset_i($signed(nrm_offset)),
                .x_vld_i (x1_vld_q),
                .x_i     (x1_q),
                .y_vld_o (y_vld),
                .y_o     (y)
            );

            assign out_valid = y_vld;
            assign out_data  = y;
        end else begin : g_plain
            assign out_valid = x1_vld_q;
            assign out_data  = x1_q;
        end
    endgenerate
endmodule

// File: rtl/pw_mac_unit_chk.sv
// Property checker for pw_mac_unit, attached with bind below.
// Assumes synchronous active-low reset and the latency rule of R6/R7.
module pw_mac_unit_chk #(
    parameter int DATA_W  = 8,
    parameter int NORM_EN = 1,
    parameter int RELU_EN = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_last,
    input logic              first_ch,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam int LAT = pw_mac_pkg::result_latency(NORM_EN);

    // R1: reset clears the strobe.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2: a closing valid cycle arms the new-point flag.
    p_close_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_last |=> first_ch);

    // R2: a non-closing valid cycle clears it.
    p_mid_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_last |=> !first_ch);

    // R3: an invalid cycle leaves the flag alone.
    p_idle_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(first_ch));

    // R6/R7: every strobe has a closing cycle LAT edges earlier.
    p_strobe_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_last, LAT));

    // R6/R7: every closing cycle yields a strobe LAT edges later.
    p_strobe_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_last, LAT) && $past(rst_n, LAT) |-> out_valid);

    // R5: with rectification no negative result is issued.
    p_no_negative_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (RELU_EN != 0) |-> !out_data[DATA_W-1]);

    // R10: the result only moves with a strobe.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));
endmodule

bind pw_mac_unit pw_mac_unit_chk #(
    .DATA_W (DATA_W),
    .NORM_EN(NORM_EN),
    .RELU_EN(RELU_EN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .first_ch (first_ch),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/sim_pw_mac_unit.sv
// Bench: three builds share one stimulus; expected values are computed
// arithmetically from the requirements.
module sim_pw_mac_unit;
    localparam int FB = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_last;
    logic [7:0] in_data, in_weight, in_bias, nrm_scale, nrm_offset;
    logic       ov0, ov1, ov2;
    logic [7:0] od0, od1, od2;

    always #10 clk = ~clk;

    pw_mac_unit #(.FRAC_BITS(FB), .NORM_EN(1), .RELU_EN(0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .in_weight(in_weight), .in_bias(in_bias),
        .nrm_scale(nrm_scale), .nrm_offset(nrm_offset),
        .out_valid(ov0), .out_data(od0));
    pw_mac_unit #(.FRAC_BITS(FB), .NORM_EN(0), .RELU_EN(1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .in_weight(in_weight), .in_bias(in_bias),
        .nrm_scale(nrm_scale), .nrm_offset(nrm_offset),
        .out_valid(ov1), .out_data(od1));
    pw_mac_unit #(.FRAC_BITS(FB), .NORM_EN(1), .RELU_EN(1)) u2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .in_weight(in_weight), .in_bias(in_bias),
        .nrm_scale(nrm_scale), .nrm_offset(nrm_offset),
        .out_valid(ov2), .out_data(od2));

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // Model state.
    int acc_m   = 0;
    bit first_m = 1'b1;
    bit hv[3];
    int hd0[3];
    int hd2[3];
    int held0 = 0, held1 = 0, held2 = 0;

    function automatic int lim(input int v, input bit relu);
        int s;
        s = v >>> FB;
        if (s > 127) return 127;
        if (relu && s < 0) return 0;
        if (s < -128) return -128;
        return s;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model the edge, check at next negedge.
    task automatic step(input string tag, input bit v, input bit l,
                        input int d, input int w, input int b,
                        input int s, input int o);
        bit ev;
        int x, e0, e1, e2;
        in_valid = v; in_last = l;
        in_data = 8'(d); in_weight = 8'(w); in_bias = 8'(b);
        nrm_scale = 8'(s); nrm_offset = 8'(o);
        @(posedge clk);
        ev = v && l;
        e0 = 0; e1 = 0; e2 = 0;
        if (v) begin
            acc_m   = (first_m ? (b * (1 << FB)) : acc_m) + d * w;
            first_m = l;
        end
        if (ev) begin
            x  = lim(acc_m, 1'b0);
            e1 = lim(acc_m, 1'b1);
            e0 = lim(s * x + o * (1 << FB), 1'b0);
            e2 = lim(s * x + o * (1 << FB), 1'b1);
        end
        hv[2] = hv[1];   hv[1] = hv[0];   hv[0] = ev;
        hd0[2] = hd0[1]; hd0[1] = hd0[0]; hd0[0] = e0;
        hd2[2] = hd2[1]; hd2[1] = hd2[0]; hd2[0] = e2;
        @(negedge clk);
        // R6 latency of the plain build, R4/R5 its value.
        chk({"R6 strobe plain ", tag}, int'(ov1), int'(ev));
        if (ev) held1 = e1;
        chk({ev ? "R5 value plain " : "R10 hold plain ", tag},
            int'($signed(od1)), held1);
        // R7 latency of the normalised builds, R8/R9 their values.
        chk({"R7 strobe norm ", tag}, int'(ov0), int'(hv[2]));
        chk({"R7 strobe norm+relu ", tag}, int'(ov2), int'(hv[2]));
        if (hv[2]) begin
            held0 = hd0[2];
            held2 = hd2[2];
        end
        chk({hv[2] ? "R8 value norm " : "R10 hold norm ", tag},
            int'($signed(od0)), held0);
        chk({hv[2] ? "R9 value norm+relu " : "R10 hold norm+relu ", tag},
            int'($signed(od2)), held2);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        static int wset[8] = '{-128, -127, -1, 0, 1, 37, 100, 127};
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; hd0[i] = 0; hd2[i] = 0;
        end
        rst_n = 1'b0;
        in_valid = 1'b1; in_last = 1'b1;
        in_data = 8'h7f; in_weight = 8'h7f; in_bias = 8'h7f;
        nrm_scale = 8'h7f; nrm_offset = 8'h7f;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held, despite active inputs.
        chk("R1 reset strobe", int'(ov0 | ov1 | ov2), 0);
        chk("R1 reset data", int'(od0 | od1 | od2), 0);
        rst_n = 1'b1;

        // R1: first pixel after reset restarts from bias.
        step("R1 first", 1, 0, 5, 6, 3, 16, 0);
        step("R1 first", 1, 1, -2, 7, 0, 16, 0);

        // R11/R4: single-channel sweep over data, weight and bias.
        for (int d = -128; d < 128; d += 3) begin
            for (int k = 0; k < 8; k++) begin
                step("R11", 1, 1, d, wset[k], (d * 7 + k * 29) % 128,
                     16 + k, k - 4);
            end
        end

        // R8/R9: scale/offset grid with fixed pixel values.
        for (int sc = -128; sc < 128; sc += 7) begin
            for (int of = -128; of < 128; of += 17) begin
                step("R8 grid", 1, 1, (of % 50), 16, sc % 9, sc, of);
            end
        end

        // R2/R3: random multi-channel pixels with idle garbage cycles.
        for (int p = 0; p < 3000; p++) begin
            int nch;
            nch = 1 + int'($urandom_range(0, 4));
            for (int c = 0; c < nch; c++) begin
                while ($urandom_range(0, 3) == 0) begin
                    step("R3 idle", 0, 1'($urandom_range(0, 1)),
                         int'($urandom_range(0, 255)) - 128,
                         int'($urandom_range(0, 255)) - 128,
                         int'($urandom_range(0, 255)) - 128,
                         int'($urandom_range(0, 255)) - 128,
                         int'($urandom_range(0, 255)) - 128);
                end
                step("R2 multi", 1, (c == nch - 1),
                     int'($urandom_range(0, 255)) - 128,
                     int'($urandom_range(0, 255)) - 128,
                     int'($urandom_range(0, 255)) - 128,
                     int'($urandom_range(0, 255)) - 128,
                     int'($urandom_range(0, 255)) - 128);
            end
        end

        // Drain the pipeline with idle cycles (R10 holds checked).
        for (int i = 0; i < 5; i++) step("R10 drain", 0, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule